// File: doc/BRIEF.md
# UART FIFO Occupancy, Trigger and DMA-Ready Controller

This block keeps track of how full the transmit and receive FIFOs of a UART are. Each FIFO holds 32 characters. An 8-bit control register sets how the block behaves. One bit enables the FIFOs. Two self-clearing bits flush either queue. Two 2-bit fields choose the receive and transmit trigger levels. One bit selects the DMA handshake style.

From the two occupancy counts and the settings, the block drives the active-low transmit-ready and receive-ready pins and the two FIFO interrupt requests. It also raises a one-cycle flag when the receive FIFO overflows.

There are two handshake styles, which this document calls single mode and block mode:
- **Single mode** is the DMA bit at 0, or the FIFOs disabled. The pins and interrupts signal one character at a time.
- **Block mode** is the DMA bit at 1 with the FIFOs enabled. The receive side is gated by the programmed trigger levels. The transmit-ready pin stays asserted until the queue is full.

The character storage itself lives elsewhere. This block sees only the push and pop strobes of the two queues. It reports the fill counts that result.

Top module: `uart_fifo_ready_ctrl`

## Requirements
- R1: After reset:
  - both counts are 0 and `ctrlRdData` reads 0x00, so the FIFOs are disabled, single mode is selected and the transmit trigger field is 00 (level 16).
  - `txRdyN` is 0, `rxRdyN` is 1, `txIrq` is 1, `rxIrq` is 0 and `rxOverrun` is 0.
- R2: `ctrlRdData` is {rx trigger field [7:6], tx trigger field [5:4], DMA bit [3], 0 [2], 0 [1], enable [0]}. A write updates it on the next cycle, and the flush bits [1] and [2] always read back as 0.
- R3: Capacity:
  - With the enable bit at 1, each count never exceeds 32. With the enable bit at 0, each queue holds one character.
  - A push to a queue at capacity is dropped.
- R4: A flush clears a count on the next cycle, and it takes priority over a push or pop in the same cycle.
  - Writing bit [1] as 1 flushes the receive count.
  - Writing bit [2] as 1 flushes the transmit count.
  - A write that changes the enable bit flushes both counts.
- R5: Counting:
  - An accepted push raises a count by one, and a pop lowers it by one.
  - A pop on an empty queue is ignored.
  - A push and a pop in the same cycle both take effect, except that a push into a queue at capacity is dropped.
- R6: In single mode, `txRdyN` is 0 exactly when the transmit count is 0, and `txIrq` is 1 exactly when the transmit count is 0.
- R7: In single mode, `rxRdyN` is 0 and `rxIrq` is 1 exactly when the receive count is at least 1.
- R8: In block mode, `rxRdyN` is 0 and `rxIrq` is 1 exactly when the receive count is at or above the receive trigger. The receive field codes 00, 01, 10 and 11 select levels 8, 16, 24 and 28.
- R9: In block mode, `txIrq` is 1 exactly when the transmit count is below the transmit trigger, and `txRdyN` is 1 exactly when the transmit count is 32.
  - The transmit field codes 00, 01, 10 and 11 select levels 16, 8, 24 and 30.
- R10: In block mode, the receive queue keeps accepting pushes past its trigger level until it holds 32 characters.
- R11: A receive push that is dropped because the queue is at capacity, with no receive flush in the same cycle, sets `rxOverrun` to 1 for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 8 | Control register write data |
| ctrlRdData | output | 8 | Control register readback |
| txPush | input | 1 | Host writes a character into the transmit queue |
| txPop | input | 1 | Transmitter takes a character from the transmit queue |
| rxPush | input | 1 | Receiver delivers a character into the receive queue |
| rxPop | input | 1 | Host reads a character from the receive queue |
| txCount | output | 6 | Transmit queue fill count |
| rxCount | output | 6 | Receive queue fill count |
| txRdyN | output | 1 | Active-low transmit-ready pin |
| rxRdyN | output | 1 | Active-low receive-ready pin |
| txIrq | output | 1 | Transmit FIFO interrupt request |
| rxIrq | output | 1 | Receive FIFO interrupt request |
| rxOverrun | output | 1 | One-cycle pulse on a dropped receive push |

## Verification
The assertions assume the push, pop and write strobes are stable around the rising edge. They also assume a full queue only ever sees pushes that are discarded, never partial writes. The stimulus drives every input on the falling edge, so each strobe is settled for a whole cycle. The stimulus deliberately hits a full queue, an empty queue, simultaneous push and pop, and flushes that coincide with traffic. These are the cases the overflow and flush properties rely on. Control writes arrive at random points, including ones that toggle the enable bit, so the flush-on-enable-change rule is exercised under load.

// File: rtl/ufr_pkg.sv
package ufr_pkg;

  // Flush strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic txClr;
    logic rxClr;
  } clrStrobe_t;

  // Control register bit positions.
  localparam int unsigned EnBit    = 0;
  localparam int unsigned RxClrBit = 1;
  localparam int unsigned TxClrBit = 2;
  localparam int unsigned DmaBit   = 3;
  localparam int unsigned TxSelLo  = 4;
  localparam int unsigned RxSelLo  = 6;

endpackage

// File: rtl/ufr_ctrl.sv
module ufr_ctrl
  import ufr_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlWrData,
  output logic [7:0]    ctrlRdData,
  output clrStrobe_t    strobes,
  output logic          fifoEn,
  output logic          blockMode,
  output logic [CW-1:0] rxTrig,
  output logic [CW-1:0] txTrig
);

  localparam logic [CW-1:0] RxLvl0 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] RxLvl1 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] RxLvl2 = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] RxLvl3 = CW'(DEPTH - DEPTH / 8);
  localparam logic [CW-1:0] TxLvl0 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TxLvl1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] TxLvl2 = CW'((3 * DEPTH) / 4);
  localparam logic [CW-1:0] TxLvl3 = CW'(DEPTH - DEPTH / 16);

  logic       enQ;
  logic       dmaQ;
  logic [1:0] rxSelQ;
  logic [1:0] txSelQ;
  logic       enFlip;

  assign enFlip = ctrlWr && (ctrlWrData[EnBit] != enQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      dmaQ   <= 1'b0;
      rxSelQ <= 2'b00;
      txSelQ <= 2'b00;
    end else if (ctrlWr) begin
      enQ    <= ctrlWrData[EnBit];
      dmaQ   <= ctrlWrData[DmaBit];
      rxSelQ <= ctrlWrData[RxSelLo +: 2];
      txSelQ <= ctrlWrData[TxSelLo +: 2];
    end
  end

  always_comb begin
    strobes.rxClr = (ctrlWr && ctrlWrData[RxClrBit]) || enFlip;
    strobes.txClr = (ctrlWr && ctrlWrData[TxClrBit]) || enFlip;
  end

  always_comb begin
    unique case (rxSelQ)
      2'b00:   rxTrig = RxLvl0;
      2'b01:   rxTrig = RxLvl1;
      2'b10:   rxTrig = RxLvl2;
      default: rxTrig = RxLvl3;
    endcase
    unique case (txSelQ)
      2'b00:   txTrig = TxLvl0;
      2'b01:   txTrig = TxLvl1;
      2'b10:   txTrig = TxLvl2;
      default: txTrig = TxLvl3;
    endcase
  end

  assign fifoEn     = enQ;
  assign blockMode  = enQ && dmaQ;
  assign ctrlRdData = {rxSelQ, txSelQ, dmaQ, 2'b00, enQ};

  // R2: a write shows up in the readback on the next cycle
  a_r2_readback : assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (ctrlRdData[7:3] == $past(ctrlWrData[7:3])) &&
               (ctrlRdData[0] == $past(ctrlWrData[0])));

endmodule

// File: rtl/ufr_occ_counter.sv
module ufr_occ_counter #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] cap,
  output logic [CW-1:0] count
);

  logic accPush;
  logic accPop;

  assign accPush = push && (count < cap);
  assign accPop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else begin
      unique case ({accPush, accPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: never above the capacity given by the datapath
  a_r3_no_overflow : assert property (@(posedge clk) disable iff (!rstN)
    count <= cap);

  // R4: a flush empties the queue on the next cycle
  a_r4_flush_empties : assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));

  // R5: without a flush the count moves by at most one per cycle
  a_r5_unit_step : assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ((int'(count) <= int'($past(count)) + 1) &&
              (int'(count) + 1 >= int'($past(count)))));

endmodule

// File: rtl/ufr_datapath.sv
module ufr_datapath
  import ufr_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  clrStrobe_t    strobes,
  input  logic          fifoEn,
  input  logic          blockMode,
  input  logic [CW-1:0] rxTrig,
  input  logic [CW-1:0] txTrig,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic          rxPop,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          txRdyN,
  output logic          rxRdyN,
  output logic          txIrq,
  output logic          rxIrq,
  output logic          rxOverrun
);

  localparam logic [CW-1:0] FullLvl = CW'(DEPTH);
  localparam logic [CW-1:0] OneLvl  = CW'(1);

  logic [CW-1:0] cap;

  assign cap = fifoEn ? FullLvl : OneLvl;

  ufr_occ_counter #(.CW(CW)) txOcc_i (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobes.txClr),
    .push (txPush),
    .pop  (txPop),
    .cap  (cap),
    .count(txCount)
  );

  ufr_occ_counter #(.CW(CW)) rxOcc_i (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobes.rxClr),
    .push (rxPush),
    .pop  (rxPop),
    .cap  (cap),
    .count(rxCount)
  );

  logic txEmpty;
  logic rxEmpty;
  logic txFull;
  logic rxAtTrig;
  logic txUnderTrig;

  assign txEmpty     = (txCount == '0);
  assign rxEmpty     = (rxCount == '0);
  assign txFull      = (txCount == FullLvl);
  assign rxAtTrig    = (rxCount >= rxTrig);
  assign txUnderTrig = (txCount < txTrig);

  always_comb begin
    if (blockMode) begin
      txRdyN = txFull;
      rxRdyN = !rxAtTrig;
      txIrq  = txUnderTrig;
      rxIrq  = rxAtTrig;
    end else begin
      txRdyN = !txEmpty;
      rxRdyN = rxEmpty;
      txIrq  = txEmpty;
      rxIrq  = !rxEmpty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxOverrun <= 1'b0;
    else       rxOverrun <= rxPush && !strobes.rxClr && (rxCount == cap);
  end

  // R11: a push into a full receive queue flags an overrun next cycle
  a_r11_overrun_flag : assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !strobes.rxClr && (rxCount == cap)) |=> rxOverrun);

  // R11: the overrun pulse lasts one cycle when the queue was drained meanwhile
  a_r11_overrun_once : assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !rxPush) |=> !rxOverrun);

  // R10: in block mode a receive push below capacity is never lost
  a_r10_fill_past_trig : assert property (@(posedge clk) disable iff (!rstN)
    (blockMode && rxPush && !rxPop && !strobes.rxClr && (rxCount < cap))
      |=> (rxCount == $past(rxCount) + 1'b1));

endmodule

// File: rtl/uart_fifo_ready_ctrl.sv
module uart_fifo_ready_ctrl
  import ufr_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlWrData,
  output logic [7:0]    ctrlRdData,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic          rxPop,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          txRdyN,
  output logic          rxRdyN,
  output logic          txIrq,
  output logic          rxIrq,
  output logic          rxOverrun
);

  clrStrobe_t    strobes;
  logic          fifoEn;
  logic          blockMode;
  logic [CW-1:0] rxTrig;
  logic [CW-1:0] txTrig;

  ufr_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData),
    .strobes   (strobes),
    .fifoEn    (fifoEn),
    .blockMode (blockMode),
    .rxTrig    (rxTrig),
    .txTrig    (txTrig)
  );

  ufr_datapath #(.DEPTH(DEPTH), .CW(CW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fifoEn    (fifoEn),
    .blockMode (blockMode),
    .rxTrig    (rxTrig),
    .txTrig    (txTrig),
    .txPush    (txPush),
    .txPop     (txPop),
    .rxPush    (rxPush),
    .rxPop     (rxPop),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txRdyN    (txRdyN),
    .rxRdyN    (rxRdyN),
    .txIrq     (txIrq),
    .rxIrq     (rxIrq),
    .rxOverrun (rxOverrun)
  );

endmodule

// File: tb/uart_fifo_ready_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_ready_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic       txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [7:0] ctrlRdData;
  logic [5:0] txCount, rxCount;
  logic       txRdyN, rxRdyN, txIrq, rxIrq, rxOverrun;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_fifo_ready_ctrl dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .txPush(txPush), .txPop(txPop),
    .rxPush(rxPush), .rxPop(rxPop), .txCount(txCount), .rxCount(rxCount),
    .txRdyN(txRdyN), .rxRdyN(rxRdyN), .txIrq(txIrq), .rxIrq(rxIrq),
    .rxOverrun(rxOverrun)
  );

  // Behavioural reference state
  int mTx, mRx, mRxSel, mTxSel;
  bit mEn, mDma, mOvr;
  int rxLvl[4] = '{8, 16, 24, 28};
  int txLvl[4] = '{16, 8, 24, 30};

  always @(posedge clk) begin
    if (!rstN) begin
      mTx = 0; mRx = 0; mRxSel = 0; mTxSel = 0;
      mEn = 0; mDma = 0; mOvr = 0;
    end else begin
      int  cap;
      bit  rxFl, txFl;
      cap  = mEn ? 32 : 1;
      rxFl = ctrlWr && (ctrlWrData[1] || (ctrlWrData[0] != mEn));
      txFl = ctrlWr && (ctrlWrData[2] || (ctrlWrData[0] != mEn));
      mOvr = rxPush && !rxFl && (mRx == cap);
      if (txFl) mTx = 0;
      else mTx = mTx + ((txPush && mTx < cap) ? 1 : 0) - ((txPop && mTx > 0) ? 1 : 0);
      if (rxFl) mRx = 0;
      else mRx = mRx + ((rxPush && mRx < cap) ? 1 : 0) - ((rxPop && mRx > 0) ? 1 : 0);
      if (ctrlWr) begin
        mEn = ctrlWrData[0]; mDma = ctrlWrData[3];
        mRxSel = int'(ctrlWrData[7:6]); mTxSel = int'(ctrlWrData[5:4]);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit blk;
      blk = mEn && mDma;
      chk("R2", "ctrlRdData", int'(ctrlRdData),
          (mRxSel << 6) | (mTxSel << 4) | (int'(mDma) << 3) | int'(mEn));
      chk("R5", "txCount", int'(txCount), mTx);
      chk("R5", "rxCount", int'(rxCount), mRx);
      chk("R11", "rxOverrun", int'(rxOverrun), int'(mOvr));
      if (blk) begin
        chk("R9", "txRdyN", int'(txRdyN), int'(mTx == 32));
        chk("R9", "txIrq", int'(txIrq), int'(mTx < txLvl[mTxSel]));
        chk("R8", "rxRdyN", int'(rxRdyN), int'(mRx < rxLvl[mRxSel]));
        chk("R8", "rxIrq", int'(rxIrq), int'(mRx >= rxLvl[mRxSel]));
      end else begin
        chk("R6", "txRdyN", int'(txRdyN), int'(mTx != 0));
        chk("R6", "txIrq", int'(txIrq), int'(mTx == 0));
        chk("R7", "rxRdyN", int'(rxRdyN), int'(mRx == 0));
        chk("R7", "rxIrq", int'(rxIrq), int'(mRx != 0));
      end
    end
  end

  task automatic step(input bit tp, input bit tq, input bit rp, input bit rq);
    txPush = tp; txPop = tq; rxPush = rp; rxPop = rq; ctrlWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0;
    ctrlWr = 1'b1; ctrlWrData = d;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1", "txCount", int'(txCount), 0);
    chk("R1", "rxCount", int'(rxCount), 0);
    chk("R1", "ctrlRdData", int'(ctrlRdData), 0);
    chk("R1", "txRdyN", int'(txRdyN), 0);
    chk("R1", "rxRdyN", int'(rxRdyN), 1);
    chk("R1", "txIrq", int'(txIrq), 1);
    chk("R1", "rxIrq", int'(rxIrq), 0);
    chk("R1", "rxOverrun", int'(rxOverrun), 0);

    // R3: FIFOs disabled, one-character holding
    step(1, 0, 1, 0);
    step(1, 0, 1, 0);
    chk("R3", "txCount disabled", int'(txCount), 1);
    chk("R11", "rxOverrun disabled", int'(rxOverrun), 1);
    step(0, 1, 0, 1);

    // Enable, single mode; fill receive past capacity
    wrCtrl(8'h01);
    for (int i = 0; i < 34; i++) step(1, 0, 1, 0);
    chk("R3", "rxCount full", int'(rxCount), 32);
    chk("R3", "txCount full", int'(txCount), 32);
    step(0, 0, 0, 0);
    chk("R11", "overrun single cycle", int'(rxOverrun), 0);

    // R4: flush with concurrent traffic
    txPush = 0; txPop = 1; rxPush = 1; rxPop = 0;
    ctrlWr = 1'b1; ctrlWrData = 8'h07;
    @(negedge clk);
    ctrlWr = 1'b0;
    chk("R4", "txCount flushed", int'(txCount), 0);
    chk("R4", "rxCount flushed", int'(rxCount), 0);
    chk("R4", "no overrun on flush", int'(rxOverrun), 0);

    // R10: block mode, rx trigger 8, fill to 32
    wrCtrl(8'h09);
    for (int i = 0; i < 32; i++) step(0, 0, 1, 0);
    chk("R10", "rxCount past trigger", int'(rxCount), 32);
    chk("R10", "rxRdyN at full", int'(rxRdyN), 0);

    // Sweep every trigger pairing in block mode
    for (int s = 0; s < 16; s++) begin
      wrCtrl(8'(8'h09 | (s << 4)) | 8'h06);
      for (int i = 0; i < 33; i++) step(1, 0, 1, 0);
      for (int i = 0; i < 33; i++) step(0, 1, 0, 1);
    end

    // R4: toggling enable flushes both
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0);
    wrCtrl(8'h08);
    chk("R4", "enable toggle tx", int'(txCount), 0);
    chk("R4", "enable toggle rx", int'(rxCount), 0);

    // Random traffic with occasional control writes
    for (int i = 0; i < 6000; i++) begin
      int ph;
      ph = (i / 300) % 2;
      if (($urandom % 64) == 0) begin
        wrCtrl(8'($urandom));
      end else begin
        step(($urandom % 4) < (ph ? 1 : 3), ($urandom % 4) < (ph ? 3 : 1),
             ($urandom % 4) < (ph ? 1 : 3), ($urandom % 4) < (ph ? 3 : 1));
      end
    end

    step(0, 0, 0, 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule